// File: doc/BRIEF.md
# Rate-Limited Line Error Counters

This block turns two receive-side error strobes into toggle-style status bits that a slow supervisor can poll. Each violation strobe advances three counters: a main counter whose status bit flips once per 256 violations, and two free counters whose bits flip once per 128 and once per 64 violations. A one-cycle millisecond tick supplies the time base for the main bit, which may change state at most once per 96 ticks.

When the main counter reaches its 256th violation before 96 ticks have passed since its last flip, the flip is held back until the interval is complete, and violations that arrive during the wait are thrown away rather than carried into the next count. The two smaller counters see every violation and are never held back. A separate 3-bit counter counts CRC-error strobes while the extended-superframe mode input is high, wrapping from 7 to 0.

A poller reads a toggle bit, compares it with the value it last saw, and knows that at least one further batch of errors has occurred. Detection of the violations and CRC errors and the serial transport of the status bits happen elsewhere.

Top module: `err_rate_counters`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `viol_main_tgl`, `viol_mid_tgl`, `viol_low_tgl` are 0 and `crc_count` is 0; the 96-tick interval counts as already elapsed after reset.
- R2: When the 256th violation since the previous main flip (or since reset) arrives in a cycle where at least 96 ticks have passed since that flip (or since reset), `viol_main_tgl` inverts on the next clock edge.
- R3: When the 256th violation arrives before 96 ticks have passed, `viol_main_tgl` holds its value and inverts one clock edge after the edge that registers the 96th tick.
- R4: Violations arriving while a flip is being held back are discarded, and each main flip restarts the main count at zero, so the next flip needs 256 new violations.
- R5: `viol_low_tgl` inverts on every 64th violation and `viol_mid_tgl` on every 128th violation, counting every violation including those discarded by the main counter, with no time limit; each inverts on the clock edge that registers the violation.
- R6: With `esf_mode` = 1, each `crc_err` strobe raises `crc_count` by one on the next edge, and a strobe at count 7 returns it to 0.
- R7: With `esf_mode` = 0, `crc_err` strobes leave `crc_count` unchanged.
- R8: Ticks alone never flip `viol_main_tgl`; with fewer than 256 violations counted, it holds regardless of how many ticks pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| viol | input | 1 | One strobe per detected line violation |
| crc_err | input | 1 | One strobe per detected CRC error |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| esf_mode | input | 1 | Enables CRC error counting |
| viol_main_tgl | output | 1 | Flips per 256 violations, at most once per 96 ticks |
| viol_mid_tgl | output | 1 | Flips per 128 violations |
| viol_low_tgl | output | 1 | Flips per 64 violations |
| crc_count | output | 3 | Wrapping CRC error count |

## Verification
The main counter is driven with a fast burst straight after reset, where the interval is already over and the flip must be immediate, and then with a second burst right after that flip, which must be held until the 96th tick; the extra violations sent during the hold, followed by a fresh count that must need all 256, separate discarding from carrying over. A slow pattern, with ticks between halves of the count, checks that a late 256th violation flips at once and that ticks alone never flip the bit. The 64 and 128 toggles are read at their first thresholds and after the held-back burst, which shows whether they counted the discarded violations. CRC strobes are sent past the wrap point in counting mode and then with the mode off.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;

    localparam int unsigned DEF_MAIN_CNT  = 256;
    localparam int unsigned DEF_MID_CNT   = 128;
    localparam int unsigned DEF_LOW_CNT   = 64;
    localparam int unsigned DEF_HOLD_TICK = 96;
    localparam int unsigned DEF_CRC_W     = 3;

    typedef enum logic {
        MT_COUNT = 1'b0,
        MT_HOLD  = 1'b1
    } main_state_e;

    typedef struct packed {
        logic main;
        logic mid;
        logic low;
    } viol_tgl_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit <= 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/err_hold_timer.sv
module err_hold_timer
    import err_cnt_pkg::*;
#(
    parameter int unsigned HOLD_TICK = DEF_HOLD_TICK
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    output logic expired
);
    localparam int unsigned TW = cnt_width(HOLD_TICK + 1);
    localparam logic [TW-1:0] HOLD_V = TW'(HOLD_TICK);

    logic [TW-1:0] elapsed_q;

    assign expired = (elapsed_q == HOLD_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed_q <= HOLD_V;
        end else if (restart) begin
            elapsed_q <= '0;
        end else if (tick && !expired) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    // R3
    elapsed_bound_chk: assert property (@(posedge clk) disable iff (rst)
        elapsed_q <= HOLD_V);

    // R3
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (elapsed_q == '0));

endmodule

// File: rtl/err_main_toggle.sv
module err_main_toggle
    import err_cnt_pkg::*;
#(
    parameter int unsigned MAIN_CNT = DEF_MAIN_CNT
) (
    input  logic clk,
    input  logic rst,
    input  logic viol,
    input  logic expired,
    output logic fire,
    output logic tgl
);
    localparam int unsigned CW = cnt_width(MAIN_CNT);
    localparam logic [CW-1:0] LAST_V = CW'(MAIN_CNT - 1);

    main_state_e   state_q;
    logic [CW-1:0] cnt_q;
    logic          tgl_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST_V);
    assign fire    = (state_q == MT_HOLD) ? expired
                                          : (viol && at_last && expired);
    assign tgl     = tgl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MT_COUNT;
            cnt_q   <= '0;
            tgl_q   <= 1'b0;
        end else if (fire) begin
            state_q <= MT_COUNT;
            cnt_q   <= '0;
            tgl_q   <= ~tgl_q;
        end else if (state_q == MT_COUNT && viol) begin
            if (at_last) begin
                state_q <= MT_HOLD;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4
    hold_count_full_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == MT_HOLD) |-> at_last);

    // R4
    restart_after_flip_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tgl_q) |-> (cnt_q == '0 && state_q == MT_COUNT));

endmodule

// File: rtl/err_tap_toggle.sv
module err_tap_toggle
    import err_cnt_pkg::*;
#(
    parameter int unsigned PERIOD = DEF_LOW_CNT
) (
    input  logic clk,
    input  logic rst,
    input  logic viol,
    output logic tgl
);
    localparam int unsigned CW = cnt_width(PERIOD);
    localparam logic [CW-1:0] LAST_V = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;
    logic          tgl_q;

    assign tgl = tgl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tgl_q <= 1'b0;
        end else if (viol) begin
            if (cnt_q == LAST_V) begin
                cnt_q <= '0;
                tgl_q <= ~tgl_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R5
    tap_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tgl_q) |-> $past(viol));

endmodule

// File: rtl/err_crc_wrap.sv
module err_crc_wrap
    import err_cnt_pkg::*;
#(
    parameter int unsigned CRC_W = DEF_CRC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err,
    input  logic             enable,
    output logic [CRC_W-1:0] count
);
    logic [CRC_W-1:0] count_q;

    assign count = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (enable && err) begin
            count_q <= count_q + 1'b1;
        end
    end

    // R6
    crc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(count_q) |-> (count_q == CRC_W'($past(count_q) + 1'b1)));

    // R7
    crc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> $stable(count_q));

endmodule

// File: rtl/err_rate_counters.sv
module err_rate_counters
    import err_cnt_pkg::*;
#(
    parameter int unsigned MAIN_CNT  = DEF_MAIN_CNT,
    parameter int unsigned MID_CNT   = DEF_MID_CNT,
    parameter int unsigned LOW_CNT   = DEF_LOW_CNT,
    parameter int unsigned HOLD_TICK = DEF_HOLD_TICK,
    parameter int unsigned CRC_W     = DEF_CRC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             viol,
    input  logic             crc_err,
    input  logic             tick_ms,
    input  logic             esf_mode,
    output logic             viol_main_tgl,
    output logic             viol_mid_tgl,
    output logic             viol_low_tgl,
    output logic [CRC_W-1:0] crc_count
);
    localparam int unsigned N_TAPS = 2;

    viol_tgl_t       tgl_s;
    logic            main_fire;
    logic            hold_expired;
    logic [N_TAPS-1:0] tap_tgl;

    err_hold_timer #(.HOLD_TICK(HOLD_TICK)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_ms),
        .restart (main_fire),
        .expired (hold_expired)
    );

    err_main_toggle #(.MAIN_CNT(MAIN_CNT)) u_main (
        .clk     (clk),
        .rst     (rst),
        .viol    (viol),
        .expired (hold_expired),
        .fire    (main_fire),
        .tgl     (tgl_s.main)
    );

    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int unsigned PER = (g == 0) ? LOW_CNT : MID_CNT;
        err_tap_toggle #(.PERIOD(PER)) u_tap (
            .clk  (clk),
            .rst  (rst),
            .viol (viol),
            .tgl  (tap_tgl[g])
        );
    end

    assign tgl_s.low = tap_tgl[0];
    assign tgl_s.mid = tap_tgl[1];

    err_crc_wrap #(.CRC_W(CRC_W)) u_crc (
        .clk    (clk),
        .rst    (rst),
        .err    (crc_err),
        .enable (esf_mode),
        .count  (crc_count)
    );

    assign viol_main_tgl = tgl_s.main;
    assign viol_mid_tgl  = tgl_s.mid;
    assign viol_low_tgl  = tgl_s.low;

    // R2
    main_rate_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(viol_main_tgl) |-> $past(hold_expired));

    // R8
    main_needs_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!viol && !main_fire && !$isunknown(tick_ms)) |=> $stable(viol_main_tgl));

endmodule

// File: tb/err_rate_counters_tb_top.sv
module err_rate_counters_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       viol = 1'b0;
    logic       crc_err = 1'b0;
    logic       tick_ms = 1'b0;
    logic       esf_mode = 1'b0;
    logic       viol_main_tgl;
    logic       viol_mid_tgl;
    logic       viol_low_tgl;
    logic [2:0] crc_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    err_rate_counters dut_i (
        .clk           (clk),
        .rst           (rst),
        .viol          (viol),
        .crc_err       (crc_err),
        .tick_ms       (tick_ms),
        .esf_mode      (esf_mode),
        .viol_main_tgl (viol_main_tgl),
        .viol_mid_tgl  (viol_mid_tgl),
        .viol_low_tgl  (viol_low_tgl),
        .crc_count     (crc_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_viol(input int n);
        if (n > 0) begin
            @(negedge clk) viol = 1'b1;
            repeat (n) @(negedge clk);
            viol = 1'b0;
        end
    endtask

    task automatic send_ticks(input int n);
        if (n > 0) begin
            @(negedge clk) tick_ms = 1'b1;
            repeat (n) @(negedge clk);
            tick_ms = 1'b0;
        end
    endtask

    task automatic send_crc(input int n);
        if (n > 0) begin
            @(negedge clk) crc_err = 1'b1;
            repeat (n) @(negedge clk);
            crc_err = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1 main", viol_main_tgl, 0);
        check("R1 mid", viol_mid_tgl, 0);
        check("R1 low", viol_low_tgl, 0);
        check("R1 crc", crc_count, 0);
    endtask

    // fast burst after reset: interval already elapsed
    task automatic t_fast_burst();
        send_viol(64);
        check("R5 low at 64", viol_low_tgl, 1);
        check("R5 mid at 64", viol_mid_tgl, 0);
        send_viol(64);
        check("R5 low at 128", viol_low_tgl, 0);
        check("R5 mid at 128", viol_mid_tgl, 1);
        send_viol(127);
        check("R2 no flip at 255", viol_main_tgl, 0);
        send_viol(1);
        check("R2 flip at 256", viol_main_tgl, 1);
        check("R5 mid at 256", viol_mid_tgl, 0);
    endtask

    // second burst straight away: flip must wait for 96 ticks
    task automatic t_held_burst();
        send_viol(256);
        check("R3 held after 256", viol_main_tgl, 1);
        send_viol(100);
        check("R3 still held", viol_main_tgl, 1);
        // 612 violations total: 9 low flips, 4 mid flips
        check("R5 low counts discarded", viol_low_tgl, 1);
        check("R5 mid counts discarded", viol_mid_tgl, 0);
        send_ticks(95);
        idle(2);
        check("R3 held at 95 ticks", viol_main_tgl, 1);
        send_ticks(1);
        check("R3 not yet at tick edge", viol_main_tgl, 1);
        idle(1);
        check("R3 flip after 96th tick", viol_main_tgl, 0);
    endtask

    // count restarted; discarded violations must not carry over
    task automatic t_discard();
        send_ticks(100);
        send_viol(255);
        check("R4 no carry at 255", viol_main_tgl, 0);
        send_viol(1);
        check("R4 flip at fresh 256", viol_main_tgl, 1);
        // 868 violations total: 13 low flips, 6 mid flips
        check("R5 low total", viol_low_tgl, 1);
        check("R5 mid total", viol_mid_tgl, 0);
    endtask

    // slow accumulation: late 256th flips at once; ticks alone do nothing
    task automatic t_slow();
        send_viol(128);
        send_ticks(120);
        idle(2);
        check("R8 ticks alone", viol_main_tgl, 1);
        send_viol(127);
        idle(2);
        check("R8 at 255 slow", viol_main_tgl, 1);
        send_viol(1);
        check("R2 late 256th flips", viol_main_tgl, 0);
    endtask

    task automatic t_crc();
        esf_mode = 1'b1;
        send_crc(5);
        check("R6 count 5", crc_count, 5);
        send_crc(2);
        check("R6 count 7", crc_count, 7);
        send_crc(1);
        check("R6 wrap to 0", crc_count, 0);
        send_crc(2);
        check("R6 count 2", crc_count, 2);
        @(negedge clk) esf_mode = 1'b0;
        send_crc(3);
        idle(1);
        check("R7 ignored when off", crc_count, 2);
    endtask

    initial begin
        t_reset_state();
        t_fast_burst();
        t_held_burst();
        t_discard();
        t_slow();
        t_crc();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule